// File: doc/BRIEF.md
# Transmit Data Retiming Interface

This block sits between a host controller and the data input of an FSK modulator running at 1200 bit/s. In retimed mode the block sets the bit rate itself, so the host needs no UART. Once per bit period the block pulls an active-low request output low. The host answers by placing the next bit on the serial data input and pulsing the strobe input high. The block captures that bit on the strobe's rising edge. At the next bit boundary it presents the bit to the modulator, and holds it there for exactly one bit period.

The strobe level chooses the mode. While the strobe stays high, the block is transparent and the serial input passes straight to the modulator. Pulling the strobe low enters retimed mode. Holding it high again for a full bit period returns the block to transparent mode. The slow-rate input selects the 75 bit/s path. That path is never retimed and always passes through.

All timing is counted in cycles of the 3.579545 MHz reference clock. The bit period is a parameter, 2983 cycles by default. The host inputs pass through a two-flop synchroniser and are edge-detected in that clock domain.

Top module: `txr_retimer`

## Requirements
- R1: In transparent mode, `mod_data_o` equals `sdata_i` combinationally and `req_no` is high. The block is in transparent mode after reset, and after the strobe has been high for a full bit period.
- R2: While `slow_rate_i` is high, `mod_data_o` follows `sdata_i` in the same cycle, whatever the mode. `req_no` is high within 4 reference cycles of `slow_rate_i` rising, and any retimed session ends.
- R3: In transparent mode with `slow_rate_i` low, driving `strobe_i` low enters retimed mode. `req_no` goes low within 4 reference cycles, and `mod_data_o` keeps the `sdata_i` level present at entry.
- R4: In retimed mode, a bit boundary occurs every `BIT_CYCLES` reference cycles, starting at entry. At each boundary `req_no` goes low and `mod_data_o` takes its new bit. The output then stays constant until the next boundary, whatever `sdata_i` and `strobe_i` do in between.
- R5: A rising edge on `strobe_i` in retimed mode captures `sdata_i` and drives `req_no` high within 4 reference cycles. The captured bit appears on `mod_data_o` at the next boundary.
- R6: If no bit is captured between two boundaries, the second boundary repeats the previous output bit.
- R7: If `strobe_i` stays high for `BIT_CYCLES` consecutive synchronised cycles, the block returns to transparent mode. While `sdata_i` holds the last retimed level, `mod_data_o` shows no change during the switch, and the switch completes within two bit periods.
- R8: During and right after reset, `req_no` is high and the block is in transparent mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 3.579545 MHz reference clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| strobe_i | input | 1 | Host strobe: held high selects transparent mode, pulsed high loads a bit |
| sdata_i | input | 1 | Serial transmit data from the host |
| slow_rate_i | input | 1 | High selects the 75 bit/s path, which always passes through |
| req_no | output | 1 | Active-low request for the next bit |
| mod_data_o | output | 1 | Data to the FSK modulator |

## Verification
The retimed path is driven with a fixed-seed random run of bits, in which the host sometimes answers a request and sometimes skips it. A skipped answer tells the repeat-previous-bit rule (R6) apart from a loaded bit. While each period is waiting for its bit, `sdata_i` is changed in the middle of the period. This separates real retiming from leakage of the raw input. Directed sequences cover entry from transparent mode, the slow-rate override in the middle of a session, and exit with the data held at the last bit. Together these show that the mode changes are glitch-free and that the request latency stays within bounds.

// File: rtl/txr_pkg.sv
// Shared types for the transmit data retiming interface.
// Assumes nothing beyond IEEE 1800-2017.
package txr_pkg;
    // Operating mode of the retimer.
    typedef enum logic {
        MODE_PASS    = 1'b0,
        MODE_RETIME  = 1'b1
    } txr_mode_e;
endpackage

// File: rtl/txr_sync.sv
// Two-flop synchroniser for a vector of slow, asynchronous host levels.
// Assumes each bit is independent (no multi-bit coherence is needed) and
// that RST_VAL gives the idle level of each input.
module txr_sync #(
    parameter int WIDTH = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    // Two-stage capture of the asynchronous inputs.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/txr_bit_timer.sv
// Bit-period timer. Counts reference cycles from 0 to BIT_CYCLES-1 and
// flags the last count as a bit boundary. Held at zero while restart_i
// is high, so the first boundary comes BIT_CYCLES cycles after release.
// Assumes BIT_CYCLES >= 2.
module txr_bit_timer #(
    parameter int BIT_CYCLES = 2983,
    localparam int CW = $clog2(BIT_CYCLES)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          restart_i,
    output logic          tick_o,
    output logic [CW-1:0] count_o
);
    localparam logic [CW-1:0] LAST = CW'(BIT_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Free-running modulo counter, cleared on restart.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || restart_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o  = !restart_i && (cnt_q == LAST);
    assign count_o = cnt_q;
endmodule

// File: rtl/txr_handshake.sv
// Mode control and request/capture handshake. Chooses the mode from the
// synchronised strobe and slow-rate levels. Captures the data bit on each
// strobe rising edge, and at each timer boundary moves the captured bit
// (or the previous bit again) to the retimed output.
// Assumes the inputs are already synchronised to clk_i.
module txr_handshake
    import txr_pkg::*;
#(
    parameter int BIT_CYCLES = 2983
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      strobe_s_i,
    input  logic      sdata_s_i,
    input  logic      slow_s_i,
    input  logic      tick_i,
    output txr_mode_e mode_o,
    output logic      bit_o,
    output logic      req_no,
    output logic      rise_o
);
    localparam int HW = $clog2(BIT_CYCLES + 1);
    localparam logic [HW-1:0] HI_LIMIT = HW'(BIT_CYCLES - 1);

    txr_mode_e     mode_q;
    logic          req_n_q;
    logic          out_bit_q;
    logic          cap_bit_q;
    logic          cap_vld_q;
    logic          strobe_q;
    logic [HW-1:0] hi_cnt_q;
    logic          rise;

    // Rising edge of the synchronised strobe.
    assign rise = strobe_s_i && !strobe_q;

    // Mode, request, capture and retimed output state.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mode_q    <= MODE_PASS;
            req_n_q   <= 1'b1;
            out_bit_q <= 1'b0;
            cap_bit_q <= 1'b0;
            cap_vld_q <= 1'b0;
            strobe_q  <= 1'b1;
            hi_cnt_q  <= '0;
        end else begin
            strobe_q <= strobe_s_i;
            case (mode_q)
                MODE_PASS: begin
                    hi_cnt_q  <= '0;
                    cap_vld_q <= 1'b0;
                    out_bit_q <= sdata_s_i;
                    if (!slow_s_i && !strobe_s_i) begin
                        mode_q  <= MODE_RETIME;
                        req_n_q <= 1'b0;
                    end else begin
                        req_n_q <= 1'b1;
                    end
                end
                default: begin
                    if (slow_s_i || (hi_cnt_q == HI_LIMIT)) begin
                        mode_q    <= MODE_PASS;
                        req_n_q   <= 1'b1;
                        cap_vld_q <= 1'b0;
                    end else begin
                        hi_cnt_q <= strobe_s_i ? hi_cnt_q + 1'b1 : '0;
                        if (tick_i) begin
                            if (rise) begin
                                out_bit_q <= sdata_s_i;
                            end else if (cap_vld_q) begin
                                out_bit_q <= cap_bit_q;
                            end
                            cap_vld_q <= 1'b0;
                            req_n_q   <= 1'b0;
                        end else if (rise) begin
                            cap_bit_q <= sdata_s_i;
                            cap_vld_q <= 1'b1;
                            req_n_q   <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign mode_o = mode_q;
    assign bit_o  = out_bit_q;
    assign req_no = req_n_q;
    assign rise_o = rise;
endmodule

// File: rtl/txr_retimer.sv
// Top of the transmit data retiming interface. Synchronises the host
// levels, runs the bit-period timer in retimed mode only, and selects
// between the raw host data and the retimed bit for the modulator.
// Assumes clk_i is the 3.579545 MHz reference and BIT_CYCLES >= 8.
module txr_retimer
    import txr_pkg::*;
#(
    parameter int BIT_CYCLES = 2983
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic strobe_i,
    input  logic sdata_i,
    input  logic slow_rate_i,
    output logic req_no,
    output logic mod_data_o
);
    localparam int CW = $clog2(BIT_CYCLES);

    logic [2:0]    sync_vec;
    logic          strobe_s;
    logic          sdata_s;
    logic          slow_s;
    logic          tick;
    logic [CW-1:0] tmr_count;
    txr_mode_e     mode;
    logic          ret_bit;
    logic          strobe_rise;

    // Host levels: strobe idles high, data and slow select idle low.
    txr_sync #(
        .WIDTH   (3),
        .RST_VAL (3'b001)
    ) sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({slow_rate_i, sdata_i, strobe_i}),
        .sync_o  (sync_vec)
    );

    assign strobe_s = sync_vec[0];
    assign sdata_s  = sync_vec[1];
    assign slow_s   = sync_vec[2];

    txr_bit_timer #(
        .BIT_CYCLES (BIT_CYCLES)
    ) timer_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (mode == MODE_PASS),
        .tick_o    (tick),
        .count_o   (tmr_count)
    );

    txr_handshake #(
        .BIT_CYCLES (BIT_CYCLES)
    ) hs_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .strobe_s_i (strobe_s),
        .sdata_s_i  (sdata_s),
        .slow_s_i   (slow_s),
        .tick_i     (tick),
        .mode_o     (mode),
        .bit_o      (ret_bit),
        .req_no     (req_no),
        .rise_o     (strobe_rise)
    );

    // Modulator data: raw host data unless a retimed session is active.
    assign mod_data_o = (slow_rate_i || (mode == MODE_PASS)) ? sdata_i : ret_bit;
endmodule

// File: rtl/txr_retimer_chk.sv
// Assertion checker for txr_retimer, attached by bind below.
// Assumes it is bound to the top with the same BIT_CYCLES.
module txr_retimer_chk
    import txr_pkg::*;
#(
    parameter int BIT_CYCLES = 2983,
    localparam int CW = $clog2(BIT_CYCLES)
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          slow_s,
    input logic          req_no,
    input txr_mode_e     mode,
    input logic          tick,
    input logic          strobe_rise,
    input logic          ret_bit,
    input logic [CW-1:0] tmr_count
);
    // Transparent mode never requests a bit.
    p_pass_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode == MODE_PASS) |-> req_no);

    // A synchronised slow-rate select leaves the request released.
    p_slow_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        slow_s |=> req_no);

    // A boundary in retimed mode requests the next bit, unless the mode ends.
    p_tick_request_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && (mode == MODE_RETIME)) |=> (!req_no || (mode == MODE_PASS)));

    // The retimed bit changes only at boundaries.
    p_hold_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((mode == MODE_RETIME) && $past(mode == MODE_RETIME) && !$past(tick))
        |-> $stable(ret_bit));

    // The timer never leaves its bit-period range.
    p_timer_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(tmr_count) < BIT_CYCLES));

    // A capture away from a boundary releases the request.
    p_capture_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_rise && !tick && !slow_s && (mode == MODE_RETIME)) |=> req_no);
endmodule

bind txr_retimer txr_retimer_chk #(
    .BIT_CYCLES (BIT_CYCLES)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slow_s      (slow_s),
    .req_no      (req_no),
    .mode        (mode),
    .tick        (tick),
    .strobe_rise (strobe_rise),
    .ret_bit     (ret_bit),
    .tmr_count   (tmr_count)
);

// File: tb/txr_retimer_tb_top.sv
// Self-checking bench for txr_retimer: fixed-seed random bit runs with
// random skipped requests, plus directed entry, slow-rate and exit cases.
module txr_retimer_tb_top;
    localparam int N = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe = 1'b1;
    logic sdata = 1'b0;
    logic slow = 1'b0;
    logic req_no;
    logic mod_data;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic exp_bit;

    always #4 clk = ~clk;

    txr_retimer #(.BIT_CYCLES(N)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .strobe_i    (strobe),
        .sdata_i     (sdata),
        .slow_rate_i (slow),
        .req_no      (req_no),
        .mod_data_o  (mod_data)
    );

    // Expected retimed bit after a period: the loaded bit, or the old one.
    function automatic logic next_bit(input bit sent, input logic b, input logic prev);
        return sent ? b : prev;
    endfunction

    task automatic chk(input bit ok, input string req, input logic act, input logic exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // One negedge inside a retimed period; the output must hold (R4).
    task automatic step(input logic hold, inout int used);
        @(negedge clk);
        used++;
        chk(mod_data == hold, "R4 hold", mod_data, hold);
    endtask

    // Run one bit period starting at a boundary negedge.
    task automatic run_period(input bit send, input logic b);
        int used = 0;
        logic hold = mod_data;
        if (send) begin
            repeat (3) step(hold, used);
            sdata = b;
            repeat (3) step(hold, used);
            strobe = 1'b1;
            repeat (4) step(hold, used);
            chk(req_no == 1'b1, "R5 release", req_no, 1'b1);
            strobe = 1'b0;
            repeat (3) step(hold, used);
        end
        sdata = ~sdata;
        while (used < N - 1) step(hold, used);
        @(negedge clk);
        exp_bit = next_bit(send, b, exp_bit);
        chk(req_no == 1'b0, "R4 request", req_no, 1'b0);
        chk(mod_data == exp_bit, send ? "R5 bit" : "R6 repeat", mod_data, exp_bit);
    endtask

    // Enter retimed mode with data level x; ends at the entry negedge.
    task automatic enter(input logic x);
        int lat = 0;
        sdata = x;
        @(negedge clk);
        strobe = 1'b0;
        slow = 1'b0;
        do begin
            @(negedge clk);
            lat++;
            chk(mod_data == x, "R3 level", mod_data, x);
        end while (req_no != 1'b0 && lat < 8);
        chk(lat <= 4, "R3 latency", req_no, 1'b0);
        exp_bit = x;
    endtask

    task automatic pass_checks(input string req);
        for (int i = 0; i < 6; i++) begin
            sdata = 1'($urandom);
            #1;
            chk(mod_data == sdata, req, mod_data, sdata);
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0604));
        repeat (3) @(negedge clk);
        chk(req_no == 1'b1, "R8 reset", req_no, 1'b1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(req_no == 1'b1, "R8 after reset", req_no, 1'b1);
        pass_checks("R1 passthrough");

        enter(1'b1);
        run_period(1'b1, 1'b1);
        for (int k = 0; k < 20; k++) begin
            run_period(($urandom % 5) != 0, 1'($urandom));
        end
        run_period(1'b0, 1'b0);

        slow = 1'b1;
        pass_checks("R2 slow passthrough");
        chk(req_no == 1'b1, "R2 release", req_no, 1'b1);

        enter(1'b0);
        for (int k = 0; k < 10; k++) begin
            run_period(($urandom % 4) != 0, 1'($urandom));
        end

        sdata = exp_bit;
        strobe = 1'b1;
        for (int i = 0; i < 2 * N; i++) begin
            @(negedge clk);
            chk(mod_data == exp_bit, "R7 glitch-free", mod_data, exp_bit);
        end
        chk(req_no == 1'b1, "R7 exit", req_no, 1'b1);
        pass_checks("R1 after exit");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule